// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This block produces the second operand for a 32-bit data-processing datapath. A source register value goes in together with a two-bit shift kind and a shift amount. The amount comes from one of two places: a 5-bit field taken from the instruction, or the low byte of another register. The block returns the shifted operand and the carry bit the shifter produces. The current carry flag is an input. It is used when the operand passes through unchanged and as the bit shifted in by rotate-with-extend.

The logic is purely combinational. Some encodings have special meanings. An immediate amount of zero means a shift by the full word for the two right shifts, and rotate-with-extend for the rotate kind. Register amounts of 32 or more each have their own carry rule. Shift kinds are encoded as 00 logical left, 01 logical right, 10 arithmetic right and 11 rotate right. `amt_sel_i` = 1 selects the register amount and 0 selects the immediate amount.

Top module: `opshift_unit`

## Requirements
- R1: In register mode only bits [7:0] of `reg_amt_i` are used. Bits [31:8] have no effect on `result_o` or `carry_o`.
- R2: In register mode, an amount of zero gives `result_o` = `src_i` and `carry_o` = `carry_i` for all four kinds.
- R3: Register logical left by n. For n = 1..31 the result is `src_i << n` and the carry is `src_i[32-n]`. For n = 32 the result is 0 and the carry is `src_i[0]`. For n > 32 both the result and the carry are 0.
- R4: Register logical right by n. For n = 1..31 the result is `src_i >> n` and the carry is `src_i[n-1]`. For n = 32 the result is 0 and the carry is `src_i[31]`. For n > 32 both the result and the carry are 0.
- R5: Register arithmetic right by n. For n = 1..31 the vacated bits are filled with bit 31 and the carry is `src_i[n-1]`. For n >= 32 every result bit equals `src_i[31]` and the carry is `src_i[31]`.
- R6: Register rotate right by a nonzero n. If n[4:0] = 0, the result is `src_i` and the carry is `src_i[31]`. Otherwise the operand is rotated by n[4:0] and the carry is `src_i[n[4:0]-1]`.
- R7: Immediate logical left. An amount of 0 gives `src_i` with `carry_o` = `carry_i`. Amounts 1..31 follow the rule in R3.
- R8: An immediate amount of 0 with either right shift acts as a shift by 32: the result is as in R4/R5 and the carry is `src_i[31]`.
- R9: An immediate amount of 0 with the rotate kind gives `{carry_i, src_i[31:1]}` with carry `src_i[0]`.
- R10: Immediate amounts 1..31 for the right shifts and the rotate follow the rules in R4, R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 32 | Operand to be shifted |
| kind_i | input | 2 | Shift kind: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| amt_sel_i | input | 1 | 1 = register amount, 0 = immediate amount |
| imm_amt_i | input | 5 | Immediate shift amount |
| reg_amt_i | input | 32 | Register holding the shift amount (low byte used) |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The assertions check, whenever the inputs change, these rules:
- the pass-through rule for a zero register amount;
- the zero result and zero carry of an oversized logical shift;
- the uniform fill of an arithmetic shift by 32 or more;
- the bit-count preservation and carry placement of rotates;
- the rotate-with-extend result.

Only the bench's sweeps can show these remaining points:
- the exact carry index for every amount from 1 to 255;
- that the upper register bits are ignored;
- the boundary at exactly 32.

The sweeps compare each output against a model that shifts one bit at a time.

// File: rtl/opshift_unit.sv
module opshift_unit #(
  parameter int DW    = 32,
  parameter int AMT_W = 8,
  parameter int IMM_W = $clog2(DW)
) (
  input  logic [DW-1:0]    src_i,
  input  logic [1:0]       kind_i,
  input  logic             amt_sel_i,
  input  logic [IMM_W-1:0] imm_amt_i,
  input  logic [DW-1:0]    reg_amt_i,
  input  logic             carry_i,
  output logic [DW-1:0]    result_o,
  output logic             carry_o
);
  localparam logic [1:0] K_LSL = 2'b00;
  localparam logic [1:0] K_LSR = 2'b01;
  localparam logic [1:0] K_ASR = 2'b10;
  localparam logic [1:0] K_ROR = 2'b11;
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DW);

  logic               imm_zero;
  logic               rrx;
  logic [AMT_W-1:0]   amt;
  logic [AMT_W-1:0]   asr_n;
  logic [IMM_W-1:0]   rot_n;
  logic [DW:0]        lsl_w;
  logic [DW:0]        lsr_w;
  logic signed [DW:0] asr_w;
  logic [2*DW-1:0]    ror_w;

  assign imm_zero = (imm_amt_i == '0);
  assign rrx      = !amt_sel_i && imm_zero && (kind_i == K_ROR);
  assign amt      = amt_sel_i ? reg_amt_i[AMT_W-1:0]
                  : (imm_zero && (kind_i == K_LSR || kind_i == K_ASR)) ? FULL
                  : AMT_W'(imm_amt_i);

  // one spare bit beside the word catches the last bit shifted out
  assign lsl_w = {1'b0, src_i} << amt;
  assign lsr_w = {src_i, 1'b0} >> amt;
  assign asr_n = (amt > FULL) ? FULL : amt;
  assign asr_w = $signed({src_i, 1'b0}) >>> asr_n;
  assign rot_n = amt[IMM_W-1:0];
  assign ror_w = {src_i, src_i} >> rot_n;

  always_comb begin
    result_o = src_i;
    carry_o  = carry_i;
    if (rrx) begin
      result_o = {carry_i, src_i[DW-1:1]};
      carry_o  = src_i[0];
    end else if (amt != '0) begin
      case (kind_i)
        K_LSL: begin
          result_o = lsl_w[DW-1:0];
          carry_o  = lsl_w[DW];
        end
        K_LSR: begin
          result_o = lsr_w[DW:1];
          carry_o  = lsr_w[0];
        end
        K_ASR: begin
          result_o = asr_w[DW:1];
          carry_o  = asr_w[0];
        end
        default: begin
          if (rot_n == '0) begin
            result_o = src_i;
            carry_o  = src_i[DW-1];
          end else begin
            result_o = ror_w[DW-1:0];
            carry_o  = ror_w[DW-1];
          end
        end
      endcase
    end
  end
endmodule

module opshift_unit_chk #(
  parameter int DW    = 32,
  parameter int AMT_W = 8,
  parameter int IMM_W = $clog2(DW)
) (
  input logic [DW-1:0]    src_i,
  input logic [1:0]       kind_i,
  input logic             amt_sel_i,
  input logic [IMM_W-1:0] imm_amt_i,
  input logic [DW-1:0]    reg_amt_i,
  input logic             carry_i,
  input logic [DW-1:0]    result_o,
  input logic             carry_o
);
  logic [AMT_W-1:0] ra;
  assign ra = reg_amt_i[AMT_W-1:0];

  always_comb begin
    // R2
    if (amt_sel_i && ra == '0)
      zero_pass_chk: assert (result_o == src_i && carry_o == carry_i);
    // R3
    if (amt_sel_i && kind_i == 2'b00 && ra > AMT_W'(DW))
      lsl_over_chk: assert (result_o == '0 && carry_o == 1'b0);
    // R5
    if (amt_sel_i && kind_i == 2'b10 && ra >= AMT_W'(DW))
      asr_fill_chk: assert (result_o == {DW{src_i[DW-1]}} && carry_o == src_i[DW-1]);
    // R6
    if (amt_sel_i && kind_i == 2'b11 && ra != '0)
      ror_bits_chk: assert ($countones(result_o) == $countones(src_i) && carry_o == result_o[DW-1]);
    // R9
    if (!amt_sel_i && kind_i == 2'b11 && imm_amt_i == '0)
      rrx_form_chk: assert (result_o == {carry_i, src_i[DW-1:1]} && carry_o == src_i[0]);
  end
endmodule

bind opshift_unit opshift_unit_chk #(.DW(DW), .AMT_W(AMT_W), .IMM_W(IMM_W)) u_chk (
  .src_i(src_i), .kind_i(kind_i), .amt_sel_i(amt_sel_i), .imm_amt_i(imm_amt_i),
  .reg_amt_i(reg_amt_i), .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o)
);

// File: tb/opshift_unit_test.sv
module opshift_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] src_i, reg_amt_i, result_o;
  logic [1:0]  kind_i;
  logic        amt_sel_i, carry_i, carry_o;
  logic [4:0]  imm_amt_i;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  opshift_unit uut (
    .src_i(src_i), .kind_i(kind_i), .amt_sel_i(amt_sel_i), .imm_amt_i(imm_amt_i),
    .reg_amt_i(reg_amt_i), .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o)
  );

  // one-bit-per-step reference
  task automatic model(input logic [31:0] v, input logic [1:0] k, input logic rm,
                       input logic [4:0] imm, input logic [31:0] ra, input logic ci,
                       output logic [31:0] r, output logic c);
    int n;
    r = v; c = ci;
    if (rm) n = int'(ra[7:0]);
    else if (imm == 0 && (k == 2'd1 || k == 2'd2)) n = 32;
    else n = int'(imm);
    if (!rm && imm == 0 && k == 2'd3) begin
      c = v[0]; r = {ci, v[31:1]};
      return;
    end
    if (n == 0) return;
    if (k == 2'd3) begin
      if (n % 32 == 0) begin c = v[31]; return; end
      n = n % 32;
    end
    for (int i = 0; i < n; i++) begin
      case (k)
        2'd0: begin c = r[31]; r = {r[30:0], 1'b0}; end
        2'd1: begin c = r[0];  r = {1'b0, r[31:1]}; end
        2'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin c = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
  endtask

  function automatic string tag(input logic [1:0] k, input logic rm, input logic [4:0] imm,
                                input logic [31:0] ra);
    if (rm) begin
      if (ra[31:8] != 0) return "R1";
      if (ra[7:0] == 0) return "R2";
      case (k) 2'd0: return "R3"; 2'd1: return "R4"; 2'd2: return "R5"; default: return "R6"; endcase
    end
    if (k == 2'd0) return "R7";
    if (imm == 0) return (k == 2'd3) ? "R9" : "R8";
    return "R10";
  endfunction

  task automatic apply(input logic [31:0] v, input logic [1:0] k, input logic rm,
                       input logic [4:0] imm, input logic [31:0] ra, input logic ci);
    logic [31:0] er; logic ec;
    @(posedge clk);
    src_i = v; kind_i = k; amt_sel_i = rm; imm_amt_i = imm; reg_amt_i = ra; carry_i = ci;
    model(v, k, rm, imm, ra, ci, er, ec);
    @(negedge clk);
    checks++;
    if (result_o !== er || carry_o !== ec) begin
      errors++;
      $display("FAIL %s kind=%0d reg=%0b imm=%0d amt=%h src=%h cin=%0b: got %h/%0b exp %h/%0b",
               tag(k, rm, imm, ra), k, rm, imm, ra, v, ci, result_o, carry_o, er, ec);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [5];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE; pats[2] = 32'hA5C3_0F96;
    pats[3] = 32'hFFFF_FFFF; pats[4] = 32'h1234_5678;
    src_i = '0; kind_i = '0; amt_sel_i = 0; imm_amt_i = '0; reg_amt_i = '0; carry_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R7 reset state: zero operand, LSL #0 passes through
    if (result_o !== 32'h0 || carry_o !== 1'b0) begin
      errors++;
      $display("FAIL R7 reset: got %h/%0b exp 00000000/0", result_o, carry_o);
    end
    rst_n = 1'b1;
    // R2..R6 register amounts 0..255
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 5; p++)
        for (int a = 0; a < 256; a++)
          apply(pats[p], 2'(k), 1'b1, 5'd0, 32'(a), 1'((a + p) & 1));
    // R7..R10 immediate amounts
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 5; p++)
        for (int a = 0; a < 32; a++)
          for (int ci = 0; ci < 2; ci++)
            apply(pats[p], 2'(k), 1'b0, 5'(a), 32'hDEAD_BE00, 1'(ci));
    // R1 upper bits of the amount register ignored
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 64; a++)
        apply(pats[a % 5], 2'(k), 1'b1, 5'(a), {$urandom() | 32'h100} & 32'hFFFF_FF00 | 32'(a * 5 % 256), 1'(a & 1));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule